// File: doc/BRIEF.md
# Four-converter differential scan sequencer

This block is a serial master that walks eight differential channels held by four external 16-bit converters. The converters share the serial clock, the data-in line and one return line, which carries both data and the conversion-complete signal. Each converter has its own active-low select. For each channel the block sends a configuration word that triggers one single-shot conversion. It then waits until the converter signals completion, or until a timeout sized for the slowest oscillator expires. The result comes back during the following transfer, so each result lags its conversion by one frame.

A converter stays selected for three transfers in a row. The first is a 32-clock frame that starts the first channel; its returned data is stale and is discarded. The second is a 32-clock frame that starts the second channel and returns the first result. The third is a 16-clock read that returns the second result. Every 32-clock frame also returns an echo of the configuration word it carried. If the echo differs from the word sent, a sticky error bit for that converter is set and the scan continues.

Top module: `adc_scan_seq`

## Requirements
- R1: The serial clock is low whenever no converter is selected. The data-out line changes only on the cycle the serial clock rises. Returned data is sampled when the serial clock falls. Each high phase of the serial clock lasts exactly `SCLK_HALF` system clocks.
- R2: At most one select is low at any time. A select is low for at least `2*SCLK_HALF` clocks before its first rising edge, and for at least `2*SCLK_HALF` clocks after its last falling edge before it is released.
- R3: A configuration word is sent MSB first as {1, mux[2:0], 000, 1, rate[2:0], 0, 0, 01, 1}. The first channel uses mux 000 and the second uses mux 011, so a rate code of 100 gives 8183h and B183h. `rate_code` is captured when a scan starts, and later changes have no effect until the next scan.
- R4: For each converter, in index order 0 to N_DEV-1, the block sends a 32-clock frame for mux 000, then a 32-clock frame for mux 011, then a 16-clock frame with the data-out line at zero. Only then is the select released. While `scan_en` stays high, the scan restarts at converter 0.
- R5: The first 16 bits of the second frame appear on `res_data` with channel 2d. The 16 bits of the third frame appear with channel 2d+1. The data bits are passed through unchanged as two's complement values, 8000h and FFFFh included. `res_valid` is a one-cycle pulse for each result.
- R6: After a 32-clock frame, once the synchronised return line has been seen high, a high-to-low transition on it ends the wait. The next frame then starts well before the timeout.
- R7: If no completion is seen, the next frame's first rising edge comes no sooner than floor(CLK_HZ*11/(10*sps)) + CLK_HZ/50000 clocks after the previous frame's last falling edge, and at most SCLK_HALF+6 clocks later than that. Codes 000 to 111 select 8, 16, 32, 64, 128, 250, 475 and 860 samples per second.
- R8: A mismatched configuration echo sets `cfg_err[d]` for converter d. The bit stays set until reset, and results from all channels are still produced.
- R9: After reset, all selects are high, the serial clock and the data-out line are low, `res_valid` is low and `cfg_err` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Starts a scan when high; the scan repeats while it stays high |
| rate_code | input | 3 | Conversion rate code, captured at the start of a scan |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converters |
| miso | input | 1 | Shared data return and conversion-complete line |
| cs_n | output | N_DEV | Active-low select, one per converter |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_chan | output | $clog2(N_DEV)+1 | Channel index of the result |
| res_data | output | 16 | Two's complement result |
| cfg_err | output | N_DEV | Sticky echo-mismatch flags, one per converter |

## Verification
The bench drives the block with converter models and scores every result against the conversion that produced it. A design that dropped the one-frame lag would report each result on the wrong channel, or would report the stale data from the first frame. A completion edge arriving while the line is left high after a frame must shorten the wait, and with the completion line held high the timeout window for the fastest rate is measured in both directions. A design that only checked the counter, or that cut the count short, would fall outside that window. One converter returns a corrupted echo: its flag alone must rise and stay set through a clean scan afterwards, and the rate input is changed mid-scan to catch a design that failed to hold the captured code.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SCLK_HALF = 4,
  parameter int N_DEV     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scan_en,
  input  logic [2:0]                 rate_code,
  output logic                       sclk,
  output logic                       mosi,
  input  logic                       miso,
  output logic [N_DEV-1:0]           cs_n,
  output logic                       res_valid,
  output logic [$clog2(N_DEV):0]     res_chan,
  output logic [15:0]                res_data,
  output logic [N_DEV-1:0]           cfg_err
);
  localparam int DW = $clog2(N_DEV);
  localparam logic [15:0] HALF_END = 16'(SCLK_HALF - 1);
  localparam logic [15:0] FULL_END = 16'(2 * SCLK_HALF - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_XFER, S_POST, S_WAIT, S_HOLD, S_GAP} st_t;

  function automatic logic [31:0] tmo_of(input logic [2:0] code);
    longint sps;
    case (code)
      3'd0: sps = 8;
      3'd1: sps = 16;
      3'd2: sps = 32;
      3'd3: sps = 64;
      3'd4: sps = 128;
      3'd5: sps = 250;
      3'd6: sps = 475;
      default: sps = 860;
    endcase
    return 32'((longint'(CLK_HZ) * 11) / (10 * sps) + longint'(CLK_HZ) / 50000);
  endfunction

  function automatic logic [15:0] cfg_word(input logic [2:0] mux, input logic [2:0] rate);
    return {1'b1, mux, 3'b000, 1'b1, rate, 2'b00, 2'b01, 1'b1};
  endfunction

  st_t               st;
  logic [DW-1:0]     dev;
  logic [1:0]        step;
  logic [2:0]        rate_q;
  logic [15:0]       cnt;
  logic [31:0]       tmo_cnt;
  logic [31:0]       tx_sh, rx_sh;
  logic [5:0]        bit_cnt;
  logic              miso_s1, miso_s2, hi_seen;

  wire [15:0] cfg_cur   = cfg_word((step == 2'd0) ? 3'b000 : 3'b011, rate_q);
  wire [31:0] frame_ld  = (step == 2'd2) ? 32'h0 : {cfg_cur, 16'h0};
  wire [5:0]  last_bit  = (step == 2'd2) ? 6'd15 : 6'd31;
  wire        rdy_fall  = hi_seen && !miso_s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; dev <= '0; step <= '0; rate_q <= 3'd4;
      cnt <= '0; tmo_cnt <= '0; tx_sh <= '0; rx_sh <= '0; bit_cnt <= '0;
      miso_s1 <= 1'b1; miso_s2 <= 1'b1; hi_seen <= 1'b0;
      sclk <= 1'b0; mosi <= 1'b0; cs_n <= '1;
      res_valid <= 1'b0; res_chan <= '0; res_data <= '0; cfg_err <= '0;
    end else begin
      miso_s1 <= miso;
      miso_s2 <= miso_s1;
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (scan_en) begin
          dev <= '0; step <= '0; rate_q <= rate_code; cnt <= '0;
          cs_n <= ~(N_DEV'(1));
          st <= S_SETUP;
        end
        S_SETUP: if (cnt == FULL_END) begin
          cnt <= '0; tx_sh <= frame_ld; bit_cnt <= '0; st <= S_XFER;
        end else cnt <= cnt + 16'd1;
        S_XFER: if (cnt == HALF_END) begin
          cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1; mosi <= tx_sh[31]; tx_sh <= {tx_sh[30:0], 1'b0};
          end else begin
            sclk <= 1'b0; rx_sh <= {rx_sh[30:0], miso}; bit_cnt <= bit_cnt + 6'd1;
            if (bit_cnt == last_bit) st <= S_POST;
          end
        end else cnt <= cnt + 16'd1;
        S_POST: begin
          hi_seen <= 1'b0; tmo_cnt <= tmo_of(rate_q); cnt <= '0;
          case (step)
            2'd0: begin
              if (rx_sh[15:0] != cfg_cur) cfg_err[dev] <= 1'b1;
              step <= 2'd1; st <= S_WAIT;
            end
            2'd1: begin
              if (rx_sh[15:0] != cfg_cur) cfg_err[dev] <= 1'b1;
              res_valid <= 1'b1; res_data <= rx_sh[31:16]; res_chan <= {dev, 1'b0};
              step <= 2'd2; st <= S_WAIT;
            end
            default: begin
              res_valid <= 1'b1; res_data <= rx_sh[15:0]; res_chan <= {dev, 1'b1};
              st <= S_HOLD;
            end
          endcase
        end
        S_WAIT: begin
          if (miso_s2) hi_seen <= 1'b1;
          if (rdy_fall || tmo_cnt == 32'd0) begin
            tx_sh <= frame_ld; bit_cnt <= '0; cnt <= '0; st <= S_XFER;
          end else tmo_cnt <= tmo_cnt - 32'd1;
        end
        S_HOLD: if (cnt == FULL_END) begin
          cnt <= '0; cs_n <= '1; st <= S_GAP;
        end else cnt <= cnt + 16'd1;
        S_GAP: if (cnt == FULL_END) begin
          cnt <= '0;
          if (dev == DW'(N_DEV - 1)) st <= S_IDLE;
          else begin
            dev <= dev + 1'b1; step <= '0;
            cs_n <= ~(N_DEV'(1) << (dev + 1'b1));
            st <= S_SETUP;
          end
        end else cnt <= cnt + 16'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (&cs_n) |-> !sclk);
  // R1
  mosi_launch_chk: assert property (@(posedge clk) disable iff (!rst_n) !$rose(sclk) |-> $stable(mosi));
  // R2
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  // R2
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cs_n) |-> !sclk);
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid);
  // R6
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == S_WAIT) |-> (!sclk && !(&cs_n)));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) (cfg_err & $past(cfg_err)) == $past(cfg_err));
endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
  localparam int CLK_HZ = 100_000;
  localparam int HALF = 2;
  localparam int ND = 4;

  logic clk = 1'b0, rst_n = 1'b0, scan_en = 1'b0;
  logic [2:0] rate_code = 3'd4;
  logic sclk, mosi, miso;
  logic [ND-1:0] cs_n, cfg_err;
  logic res_valid;
  logic [2:0] res_chan;
  logic [15:0] res_data;

  always #5 clk = ~clk;

  adc_scan_seq #(.CLK_HZ(CLK_HZ), .SCLK_HALF(HALF), .N_DEV(ND)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .rate_code(rate_code),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data), .cfg_err(cfg_err));

  int nchk = 0, nfail = 0, nres = 0, cnum = 0;
  logic [18:0] sbq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int tmo_exp(input int sps);
    return (CLK_HZ * 11) / (10 * sps) + CLK_HZ / 50000;
  endfunction

  function automatic logic [15:0] conv_val(input int ch, input int n);
    case (ch)
      0: return 16'h8000;
      1: return 16'hFFFF;
      2: return 16'h7FFF;
      3: return 16'h0001;
      default: return 16'(ch * 16'h1357 + n * 16'h0101);
    endcase
  endfunction

  // converter models
  logic [15:0] pend [ND];
  logic [15:0] corrupt [ND];
  logic [15:0] rxcfg = '0, exp_cfg;
  logic [31:0] rxs = '0;
  logic [2:0]  exp_rate = 3'd4;
  logic miso_r = 1'b1, prev_sclk = 1'b0;
  logic [ND-1:0] prev_cs = '1;
  int bitc = 0, frames = 0, rdy_t = 0, last_dev = ND - 1, sel, ch;
  int cyc = 0, cs_fall_t = 0, last_fall_t = 0, hi_run = 0, gap = 0, max_gap = 0;
  bit rdy_en = 1, first_rise = 0, wid_bad = 0, cs_bad = 0;
  int rdy_dly = 20;
  logic [15:0] v, echo;
  assign miso = miso_r;

  initial for (int i = 0; i < ND; i++) begin pend[i] = '0; corrupt[i] = '0; end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      sel = -1;
      for (int i = 0; i < ND; i++) if (!cs_n[i]) sel = i;
      for (int i = 0; i < ND; i++) begin
        if (prev_cs[i] && !cs_n[i]) begin
          chk(i == (last_dev + 1) % ND, "R4", "device order", i, (last_dev + 1) % ND);
          last_dev = i; bitc = 0; frames = 0; cs_fall_t = cyc; first_rise = 1; gap = 0;
        end
        if (!prev_cs[i] && cs_n[i]) begin
          chk(frames == 2 && bitc == 16, "R4", "frames then bits at release", frames * 256 + bitc, 2 * 256 + 16);
          chk(rxs[15:0] == 16'h0, "R4", "read frame data-out", rxs[15:0], 0);
          if (cyc - last_fall_t < 2 * HALF) cs_bad = 1;
        end
      end
      if (sel >= 0) begin
        if (rdy_t > 0) begin
          rdy_t--;
          if (rdy_t == 0) miso_r = 1'b0;
        end
        if (sclk) hi_run++;
        else gap++;
        if (sclk && !prev_sclk) begin
          if (first_rise && (cyc - cs_fall_t < 2 * HALF)) cs_bad = 1;
          first_rise = 0;
          if (gap > max_gap) max_gap = gap;
          gap = 0;
          echo = rxcfg ^ corrupt[sel];
          miso_r = (bitc < 16) ? pend[sel][15 - bitc] : echo[31 - bitc];
          rdy_t = 0;
        end
        if (!sclk && prev_sclk) begin
          if (hi_run != HALF) wid_bad = 1;
          hi_run = 0;
          last_fall_t = cyc;
          rxs = {rxs[30:0], mosi};
          bitc++;
          if (bitc == 16) rxcfg = rxs[15:0];
          if (bitc == 32) begin
            exp_cfg = {1'b1, (frames == 0) ? 3'b000 : 3'b011, 3'b000, 1'b1, exp_rate, 2'b00, 2'b01, 1'b1};
            chk(rxcfg == exp_cfg, "R3", "configuration word", rxcfg, exp_cfg);
            ch = 2 * sel + ((rxcfg[14:12] == 3'b011) ? 1 : 0);
            v = conv_val(ch, cnum); cnum++;
            pend[sel] = v;
            sbq.push_back({3'(ch), v});
            frames++; bitc = 0; miso_r = 1'b1;
            if (rdy_en) rdy_t = rdy_dly;
          end
        end
      end else begin
        miso_r = 1'b1; rdy_t = 0;
      end
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      nres++;
      if (sbq.size() == 0) chk(0, "R5", "unexpected result", {13'h0, res_chan, res_data}, 0);
      else begin
        logic [18:0] e;
        e = sbq.pop_front();
        chk({res_chan, res_data} == e, "R5", "channel and data", {13'h0, res_chan, res_data}, {13'h0, e});
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R4 watchdog: actual hung expected scan completion");
    summary();
  end

  task automatic run_scans(input int n);
    int base;
    base = nres;
    @(negedge clk) scan_en = 1'b1;
    while (&cs_n) @(negedge clk);
    if (n == 1) scan_en = 1'b0;
    else begin
      while (nres < base + 8) @(negedge clk);
      while (cs_n[0]) @(negedge clk);
      scan_en = 1'b0;
    end
    while (nres < base + 8 * n || !(&cs_n)) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(nres == base + 8 * n, "R5", "result count", nres - base, 8 * n);
    chk(sbq.size() == 0, "R5", "pending results", sbq.size(), 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(cs_n == '1, "R9", "cs_n", cs_n, 4'hF);
    chk(sclk == 1'b0, "R9", "sclk", sclk, 0);
    chk(mosi == 1'b0, "R9", "mosi", mosi, 0);
    chk(res_valid == 1'b0, "R9", "res_valid", res_valid, 0);
    chk(cfg_err == '0, "R9", "cfg_err", cfg_err, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // ready-edge scan at code 100
    max_gap = 0;
    run_scans(1);
    chk(max_gap < tmo_exp(128), "R6", "longest idle gap with ready edge", max_gap, tmo_exp(128));
    chk(cfg_err == '0, "R8", "no mismatch", cfg_err, 0);
    chk(!wid_bad, "R1", "sclk high width", wid_bad, 0);
    chk(!cs_bad, "R2", "select setup/hold", cs_bad, 0);

    // timeout scan at code 111, rate changed mid-scan
    rdy_en = 0; rate_code = 3'd7; exp_rate = 3'd7; max_gap = 0;
    fork
      run_scans(1);
      begin
        while (&cs_n) @(negedge clk);
        rate_code = 3'd0;
      end
    join
    chk(max_gap >= tmo_exp(860) && max_gap <= tmo_exp(860) + HALF + 6, "R7", "timeout gap", max_gap, tmo_exp(860));

    // corrupted echo on converter 2
    rdy_en = 1; rate_code = 3'd4; exp_rate = 3'd4; corrupt[2] = 16'h0004;
    run_scans(1);
    chk(cfg_err == 4'b0100, "R8", "mismatch flag", cfg_err, 4'b0100);
    corrupt[2] = 16'h0000;
    run_scans(1);
    chk(cfg_err == 4'b0100, "R8", "flag sticky", cfg_err, 4'b0100);

    // continuous scanning
    run_scans(2);
    chk(!wid_bad, "R1", "sclk high width overall", wid_bad, 0);
    chk(!cs_bad, "R2", "select setup/hold overall", cs_bad, 0);
    summary();
  end
endmodule